// File: doc/BRIEF.md
# Falling-Edge Register File with Zero Entry

This block is a small multi-ported storage array for an integer datapath. It has thirty-two 32-bit entries, two independent read ports that are purely combinational, and one write port. A write happens on the falling clock edge. A datapath that reads operands in the first half of a cycle can therefore see, in the second half, a value written in that same cycle.

Entry zero is a constant. It always reads as zero, and any write aimed at it is dropped. Entries one to thirty-one are cleared by a synchronous, active-high reset. The reset is sampled on the same falling edge that performs writes.

Top module: `zreg_file`

## Requirements
- R1: While the reset input is high at a falling clock edge, entries 1 to 31 become zero at that edge. Reset takes priority over a write at the same edge.
- R2: Reading with index 0 on either port always returns 32'h0, even after a write enabled to index 0 with non-zero data.
- R3: When the write enable is 1 at a falling clock edge, the entry selected by the 5-bit write index takes the 32-bit write data at that edge.
- R4: When the write enable is 0 at a falling clock edge, no entry changes.
- R5: Each read port returns, combinationally, the current content of the entry selected by its own 5-bit index. The two ports are independent of each other.
- R6: When a read index equals the write index, the port returns the old value until the falling edge and the new value after it.
- R7: When both read indices select the same entry, both ports return the same value.
- R8: A write changes only the addressed entry. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its falling edge |
| rst | input | 1 | Synchronous active-high clear of entries 1..31 |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write entry index |
| wr_data | input | 32 | Write data |
| rd_idx_a | input | 5 | Read port A index |
| rd_data_a | output | 32 | Read port A data |
| rd_idx_b | input | 5 | Read port B index |
| rd_data_b | output | 32 | Read port B data |

## Verification
The hardest case to reach from the ports is a read of an entry during the same cycle in which that entry is being written. The value must be the old one before the falling edge and the new one after it. The bench builds this case on purpose: it points a read index at the write index, samples once after the rising edge and again after the falling edge, and compares both samples with a reference array. Random traffic with a fixed seed also produces many such collisions, as well as writes to entry zero and equal read indices.

// File: rtl/zreg_file.sv
module zreg_file #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_idx_a,
  output logic [W-1:0]  rd_data_a,
  input  logic [AW-1:0] rd_idx_b,
  output logic [W-1:0]  rd_data_b
);

  logic [W-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_ent
    always_ff @(negedge clk) begin
      if (rst)                                  regs[i] <= '0;
      else if (wr_en && wr_idx == AW'(i))       regs[i] <= wr_data;
    end
  end

  assign rd_data_a = regs[rd_idx_a];
  assign rd_data_b = regs[rd_idx_b];

  a_r2_zero_a: assert property (@(posedge clk) rd_idx_a == '0 |-> rd_data_a == '0);
  a_r2_zero_b: assert property (@(posedge clk) rd_idx_b == '0 |-> rd_data_b == '0);
  a_r7_same: assert property (@(posedge clk) rd_idx_a == rd_idx_b |-> rd_data_a == rd_data_b);
  a_r1_clear: assert property (@(negedge clk) $past(rst) |-> rd_data_a == '0 && rd_data_b == '0);
  a_r4_hold: assert property (@(negedge clk) disable iff (rst)
    !$past(wr_en) && !$past(rst) && $stable(rd_idx_a) |-> $stable(rd_data_a));
  a_r3_write: assert property (@(negedge clk) disable iff (rst)
    $past(wr_en) && !$past(rst) && $past(wr_idx) != '0 && rd_idx_a == $past(wr_idx)
    |-> rd_data_a == $past(wr_data));

endmodule

// File: tb/sim_zreg_file.sv
module sim_zreg_file;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [4:0] wr_idx = '0, rd_idx_a = '0, rd_idx_b = '0;
  logic [31:0] wr_data = '0, rd_data_a, rd_data_b;
  logic [31:0] model [32];
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  zreg_file u0 (.clk, .rst, .wr_en, .wr_idx, .wr_data,
                .rd_idx_a, .rd_data_a, .rd_idx_b, .rd_data_b);

  function automatic logic [31:0] expect_rd(input logic [4:0] ix);
    return (ix == 0) ? 32'h0 : model[ix];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst) for (int i = 0; i < 32; i++) model[i] = '0;
    else if (wr_en && wr_idx != 0) model[wr_idx] = wr_data;
  endtask

  // One cycle: inputs set after rising edge, pre-sample, falling edge, post-sample.
  task automatic cycle(input string req, input logic r, input logic we,
                       input logic [4:0] wi, input logic [31:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb);
    @(posedge clk); #1;
    rst = r; wr_en = we; wr_idx = wi; wr_data = wd; rd_idx_a = ra; rd_idx_b = rb;
    #2;
    chk({req, " pre A"}, rd_data_a, expect_rd(ra));
    chk({req, " pre B"}, rd_data_b, expect_rd(rb));
    @(negedge clk);
    model_edge();
    #1;
    chk({req, " post A"}, rd_data_a, expect_rd(ra));
    chk({req, " post B"}, rd_data_b, expect_rd(rb));
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) model[i] = 'x;
    @(negedge clk); model_edge(); #1;
    for (int i = 0; i < 32; i++) begin
      rd_idx_a = 5'(i); rd_idx_b = 5'(31 - i); #1;
      chk("R1 reset A", rd_data_a, 32'h0);
      chk("R1 reset B", rd_data_b, 32'h0);
    end
    cycle("R3 write", 0, 1, 5'd5, 32'hDEADBEEF, 5'd5, 5'd0);
    cycle("R6 same-cycle", 0, 1, 5'd5, 32'h12345678, 5'd5, 5'd5);
    cycle("R2 write x0", 0, 1, 5'd0, 32'hFFFFFFFF, 5'd0, 5'd0);
    cycle("R4 no enable", 0, 0, 5'd5, 32'hAAAA5555, 5'd5, 5'd31);
    cycle("R8 neighbour", 0, 1, 5'd6, 32'h0BADF00D, 5'd5, 5'd6);
    cycle("R7 same idx", 0, 0, 5'd0, 32'h0, 5'd6, 5'd6);
    cycle("R1 reset prio", 1, 1, 5'd7, 32'h77777777, 5'd7, 5'd5);
    cycle("R5 after reset", 0, 0, 5'd0, 32'h0, 5'd6, 5'd7);
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] wi, ra, rb;
      wi = 5'($urandom_range(0, 31));
      ra = ($urandom_range(0, 3) == 0) ? wi : 5'($urandom_range(0, 31));
      rb = ($urandom_range(0, 3) == 0) ? ra : 5'($urandom_range(0, 31));
      cycle("R5/R6/R8 random", ($urandom_range(0, 199) == 0), $urandom_range(0, 1),
            wi, $urandom, ra, rb);
    end
    for (int i = 0; i < 32; i++) cycle("R8 sweep", 0, 0, 5'd0, 32'h0, 5'(i), 5'(i));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule